// File: doc/BRIEF.md
# Chained Multicast Transfer Endpoint

This block is one station of a multicast transfer built as a chain rather than by router replication. Each station is either the head, which owns the source buffer, or a member, which owns a destination buffer. Stations talk only by ordinary point-to-point packets. The head first hands every member its two neighbours and its buffer base. It then waits until a go-ahead returns from the far end of the chain. It streams the words down the chain and finally waits for a completion notice that also travels back from the far end.

A member that has no downstream neighbour is the last station. It issues the go-ahead as soon as it learns its links, and it issues the completion notice once it has taken the final word. Any other member passes the go-ahead and the completion notice upstream only after receiving them from downstream. It hands each data word on to its downstream neighbour in the same cycle that it stores the word locally. When the outgoing link stalls, it holds off the incoming link, so no word is ever lost.

Packets are 43-bit vectors. From the MSB down they hold kind[42:41], destination node[40:37], source node[36:33], end flag[32] and body[31:0]. A configuration body carries upstream node[15:12], downstream node[11:8] and buffer base[7:0]. The node value 4'hF means "no neighbour".

Top module: `chain_dma_endpoint`

## Requirements
- R1: While reset is high and in the cycle after it, out_vld, mem_we, in_rdy and done are all 0.
- R2: When started with role_init=1, the head emits one configuration packet (kind 2'b00) per table entry, in table order, one per accepted cycle. Entry i receives upstream = own node for i=0, else entry i-1; downstream = 4'hF for the last entry, else entry i+1; and base = the table base of entry i.
- R3: The head emits no data packet before it has accepted a go-ahead packet (kind 2'b01).
- R4: After the go-ahead, the head emits xfer_len data packets (kind 2'b10) to table entry 0. Word k carries mem_rdata read at src_base+k, and only the final word has the end flag set.
- R5: The head raises done in the cycle after it accepts a completion packet (kind 2'b11), and holds it until the next start.
- R6: A member whose downstream node is not 4'hF emits nothing after configuration until it accepts a go-ahead. It then sends exactly one go-ahead to its upstream node.
- R7: A member whose downstream node is 4'hF sends a go-ahead to its upstream node right after configuration, with no go-ahead received.
- R8: A non-last member forwards each accepted data word in the same cycle, with destination = downstream node, source = own node, and body and end flag unchanged. It also writes the word at base+k for the k-th word.
- R9: A non-last member with out_rdy low holds in_rdy and mem_we low, so no word is stored or dropped in a stalled cycle.
- R10: The last member sends a completion packet upstream after its final word. A non-last member sends one only after accepting a completion packet from downstream. Both then raise done.
- R11: A packet of a kind the current phase does not expect is not accepted (in_rdy stays 0) and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a transfer |
| role_init | input | 1 | 1 = head, 0 = member; sampled with start |
| my_addr | input | 4 | Own node number |
| fol_cnt | input | 3 | Number of members in the chain (head only, at least 1) |
| xfer_len | input | 8 | Words to send (head only, at least 1) |
| src_base | input | 8 | Source buffer base (head only) |
| tbl_we | input | 1 | Write strobe for the chain table |
| tbl_idx | input | 2 | Chain table position |
| tbl_node | input | 4 | Member node at that position |
| tbl_base | input | 8 | Member buffer base at that position |
| in_vld | input | 1 | Incoming packet valid |
| in_pkt | input | 43 | Incoming packet |
| in_rdy | output | 1 | Incoming packet accepted |
| out_vld | output | 1 | Outgoing packet valid |
| out_pkt | output | 43 | Outgoing packet |
| out_rdy | input | 1 | Network can take the outgoing packet |
| mem_we | output | 1 | Local buffer write strobe |
| mem_waddr | output | 8 | Local buffer write address |
| mem_wdata | output | 32 | Local buffer write data |
| mem_raddr | output | 8 | Local buffer read address (combinational read) |
| mem_rdata | input | 32 | Local buffer read data |
| done | output | 1 | Transfer complete for this station |

## Verification
In a middle member, forwarding a word downstream and storing it locally fall in the same cycle, and both depend on the downstream link being ready. The bench throttles out_rdy with a repeating pattern while it streams words into a middle member. Every accepted word must appear once in the forwarded-packet queue and once in the write queue, at the right address. In every stalled cycle the bench also requires that neither the input is taken nor a write is made.

// File: rtl/chain_pkg.sv
package chain_pkg;
    localparam int NODE_W  = 4;
    localparam int WORD_W  = 32;
    localparam int MADDR_W = 8;
    localparam logic [NODE_W-1:0] NODE_NONE = '1;

    typedef enum logic [1:0] {
        K_CFG   = 2'b00,
        K_GRANT = 2'b01,
        K_DATA  = 2'b10,
        K_FIN   = 2'b11
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic [NODE_W-1:0]   dst;
        logic [NODE_W-1:0]   src;
        logic                last;
        logic [WORD_W-1:0]   body;
    } pkt_t;

    localparam int PKT_W = $bits(pkt_t);

    typedef struct packed {
        logic [NODE_W-1:0]  prev;
        logic [NODE_W-1:0]  next;
        logic [MADDR_W-1:0] base;
    } link_t;

    localparam int LINK_W = $bits(link_t);

    function automatic pkt_t make_pkt(kind_e k, logic [NODE_W-1:0] d,
                                      logic [NODE_W-1:0] s, logic l,
                                      logic [WORD_W-1:0] b);
        pkt_t p;
        p.kind = k;
        p.dst  = d;
        p.src  = s;
        p.last = l;
        p.body = b;
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] pack_link(link_t x);
        return {{(WORD_W-LINK_W){1'b0}}, x};
    endfunction

    function automatic link_t unpack_link(logic [WORD_W-1:0] b);
        return link_t'(b[LINK_W-1:0]);
    endfunction
endpackage

// File: rtl/chain_init_ctrl.sv
module chain_init_ctrl
    import chain_pkg::*;
#(
    parameter int MAX_FOL = 4,
    parameter int LEN_W   = 8,
    localparam int CNT_W  = $clog2(MAX_FOL + 1),
    localparam int IDX_W  = (MAX_FOL > 1) ? $clog2(MAX_FOL) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [NODE_W-1:0]  my_addr,
    input  logic [CNT_W-1:0]   fol_cnt,
    input  logic [LEN_W-1:0]   xfer_len,
    input  logic [MADDR_W-1:0] src_base,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [NODE_W-1:0]  tbl_node,
    input  logic [MADDR_W-1:0] tbl_base,
    input  logic               in_vld,
    input  pkt_t               in_pkt,
    output logic               in_rdy,
    output logic               out_vld,
    output pkt_t               out_pkt,
    input  logic               out_rdy,
    output logic [MADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0]  rd_data,
    output logic               done
);
    typedef enum logic [2:0] {I_IDLE, I_CFG, I_GRANT, I_DATA, I_FIN, I_DONE} ist_e;

    ist_e               st;
    logic [IDX_W-1:0]   idx, idx_last;
    logic [LEN_W-1:0]   cnt, len_q;
    logic [NODE_W-1:0]  my_q;
    logic [MADDR_W-1:0] sbase_q;
    logic [NODE_W-1:0]  node_tab [MAX_FOL];
    logic [MADDR_W-1:0] base_tab [MAX_FOL];
    logic [NODE_W-1:0]  prev_n, next_n;
    logic               word_last;

    always_ff @(posedge clk) begin
        if (tbl_we) begin
            node_tab[tbl_idx] <= tbl_node;
            base_tab[tbl_idx] <= tbl_base;
        end
    end

    always_comb begin
        prev_n    = (idx == '0) ? my_q : node_tab[idx - 1'b1];
        next_n    = (idx == idx_last) ? NODE_NONE : node_tab[idx + 1'b1];
        word_last = (cnt == len_q - 1'b1);
        rd_addr   = sbase_q + MADDR_W'(cnt);
        out_vld   = 1'b0;
        out_pkt   = make_pkt(K_CFG, '0, '0, 1'b0, '0);
        case (st)
            I_CFG: begin
                out_vld = 1'b1;
                out_pkt = make_pkt(K_CFG, node_tab[idx], my_q, 1'b0,
                                   pack_link('{prev: prev_n, next: next_n, base: base_tab[idx]}));
            end
            I_DATA: begin
                out_vld = 1'b1;
                out_pkt = make_pkt(K_DATA, node_tab[0], my_q, word_last, rd_data);
            end
            default: ;
        endcase
        in_rdy = ((st == I_GRANT) && (in_pkt.kind == K_GRANT)) ||
                 ((st == I_FIN)   && (in_pkt.kind == K_FIN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= I_IDLE;
            idx      <= '0;
            idx_last <= '0;
            cnt      <= '0;
            len_q    <= '0;
            my_q     <= '0;
            sbase_q  <= '0;
        end else begin
            case (st)
                I_IDLE, I_DONE: if (start) begin
                    my_q     <= my_addr;
                    len_q    <= xfer_len;
                    sbase_q  <= src_base;
                    idx_last <= IDX_W'(fol_cnt - 1'b1);
                    idx      <= '0;
                    cnt      <= '0;
                    st       <= I_CFG;
                end
                I_CFG: if (out_rdy) begin
                    if (idx == idx_last) st <= I_GRANT;
                    else                 idx <= idx + 1'b1;
                end
                I_GRANT: if (in_vld && in_rdy) st <= I_DATA;
                I_DATA: if (out_rdy) begin
                    if (word_last) st <= I_FIN;
                    else           cnt <= cnt + 1'b1;
                end
                I_FIN: if (in_vld && in_rdy) st <= I_DONE;
                default: st <= I_IDLE;
            endcase
        end
    end

    assign done = (st == I_DONE);
endmodule

// File: rtl/chain_fol_ctrl.sv
module chain_fol_ctrl
    import chain_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [NODE_W-1:0]  my_addr,
    input  logic               in_vld,
    input  pkt_t               in_pkt,
    output logic               in_rdy,
    output logic               out_vld,
    output pkt_t               out_pkt,
    input  logic               out_rdy,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_waddr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic               done
);
    typedef enum logic [3:0] {
        F_IDLE, F_CFG, F_GRANT, F_SGRANT, F_WDATA, F_RDATA, F_RFIN, F_SFIN, F_DONE
    } fst_e;

    fst_e               st;
    logic [NODE_W-1:0]  my_q, prev_q, next_q;
    logic [MADDR_W-1:0] wptr;
    logic               is_tail, in_data, take;
    link_t              lk;

    always_comb begin
        is_tail = (next_q == NODE_NONE);
        in_data = (st == F_WDATA) || (st == F_RDATA);
        lk      = unpack_link(in_pkt.body);
        case (st)
            F_CFG:            in_rdy = (in_pkt.kind == K_CFG);
            F_GRANT:          in_rdy = (in_pkt.kind == K_GRANT);
            F_WDATA, F_RDATA: in_rdy = (in_pkt.kind == K_DATA) && (is_tail || out_rdy);
            F_RFIN:           in_rdy = (in_pkt.kind == K_FIN);
            default:          in_rdy = 1'b0;
        endcase
        take    = in_vld && in_rdy;
        out_vld = 1'b0;
        out_pkt = make_pkt(K_CFG, '0, '0, 1'b0, '0);
        case (st)
            F_SGRANT: begin
                out_vld = 1'b1;
                out_pkt = make_pkt(K_GRANT, prev_q, my_q, 1'b0, '0);
            end
            F_WDATA, F_RDATA: begin
                out_vld = in_vld && (in_pkt.kind == K_DATA) && !is_tail;
                out_pkt = make_pkt(K_DATA, next_q, my_q, in_pkt.last, in_pkt.body);
            end
            F_SFIN: begin
                out_vld = 1'b1;
                out_pkt = make_pkt(K_FIN, prev_q, my_q, 1'b0, '0);
            end
            default: ;
        endcase
        mem_we    = take && in_data;
        mem_waddr = wptr;
        mem_wdata = in_pkt.body;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= F_IDLE;
            my_q   <= '0;
            prev_q <= '0;
            next_q <= NODE_NONE;
            wptr   <= '0;
        end else begin
            case (st)
                F_IDLE, F_DONE: if (start) begin
                    my_q <= my_addr;
                    st   <= F_CFG;
                end
                F_CFG: if (take) begin
                    prev_q <= lk.prev;
                    next_q <= lk.next;
                    wptr   <= lk.base;
                    st     <= (lk.next == NODE_NONE) ? F_SGRANT : F_GRANT;
                end
                F_GRANT:  if (take) st <= F_SGRANT;
                F_SGRANT: if (out_rdy) st <= F_WDATA;
                F_WDATA, F_RDATA: if (take) begin
                    wptr <= wptr + 1'b1;
                    if (in_pkt.last) st <= is_tail ? F_SFIN : F_RFIN;
                    else             st <= F_RDATA;
                end
                F_RFIN: if (take) st <= F_SFIN;
                F_SFIN: if (out_rdy) st <= F_DONE;
                default: st <= F_IDLE;
            endcase
        end
    end

    assign done = (st == F_DONE);
endmodule

// File: rtl/chain_dma_endpoint.sv
module chain_dma_endpoint
    import chain_pkg::*;
#(
    parameter int MAX_FOL = 4,
    parameter int LEN_W   = 8,
    localparam int CNT_W  = $clog2(MAX_FOL + 1),
    localparam int IDX_W  = (MAX_FOL > 1) ? $clog2(MAX_FOL) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               role_init,
    input  logic [NODE_W-1:0]  my_addr,
    input  logic [CNT_W-1:0]   fol_cnt,
    input  logic [LEN_W-1:0]   xfer_len,
    input  logic [MADDR_W-1:0] src_base,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [NODE_W-1:0]  tbl_node,
    input  logic [MADDR_W-1:0] tbl_base,
    input  logic               in_vld,
    input  logic [PKT_W-1:0]   in_pkt,
    output logic               in_rdy,
    output logic               out_vld,
    output logic [PKT_W-1:0]   out_pkt,
    input  logic               out_rdy,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_waddr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic [MADDR_W-1:0] mem_raddr,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               done
);
    logic role_q;
    logic i_rdy, i_ovld, i_done, f_rdy, f_ovld, f_done;
    pkt_t pin, i_opkt, f_opkt;

    assign pin = pkt_t'(in_pkt);

    always_ff @(posedge clk) begin
        if (rst)        role_q <= 1'b0;
        else if (start) role_q <= role_init;
    end

    chain_init_ctrl #(.MAX_FOL(MAX_FOL), .LEN_W(LEN_W)) u_head (
        .clk(clk), .rst(rst), .start(start && role_init),
        .my_addr(my_addr), .fol_cnt(fol_cnt), .xfer_len(xfer_len), .src_base(src_base),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_node(tbl_node), .tbl_base(tbl_base),
        .in_vld(in_vld && role_q), .in_pkt(pin), .in_rdy(i_rdy),
        .out_vld(i_ovld), .out_pkt(i_opkt), .out_rdy(out_rdy),
        .rd_addr(mem_raddr), .rd_data(mem_rdata), .done(i_done)
    );

    chain_fol_ctrl u_member (
        .clk(clk), .rst(rst), .start(start && !role_init), .my_addr(my_addr),
        .in_vld(in_vld && !role_q), .in_pkt(pin), .in_rdy(f_rdy),
        .out_vld(f_ovld), .out_pkt(f_opkt), .out_rdy(out_rdy),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .done(f_done)
    );

    always_comb begin
        in_rdy  = role_q ? i_rdy  : f_rdy;
        out_vld = role_q ? i_ovld : f_ovld;
        out_pkt = role_q ? i_opkt : f_opkt;
        done    = role_q ? i_done : f_done;
    end
endmodule

// File: rtl/chain_dma_endpoint_chk.sv
module chain_dma_endpoint_chk
    import chain_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               in_vld,
    input logic [PKT_W-1:0]   in_pkt,
    input logic               in_rdy,
    input logic               out_vld,
    input logic [PKT_W-1:0]   out_pkt,
    input logic               out_rdy,
    input logic               mem_we,
    input logic [WORD_W-1:0]  mem_wdata,
    input logic               done
);
    pkt_t pi, po;
    logic got_grant, seen_last;

    assign pi = pkt_t'(in_pkt);
    assign po = pkt_t'(out_pkt);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            got_grant <= 1'b0;
            seen_last <= 1'b0;
        end else if (in_vld && in_rdy) begin
            if (pi.kind == K_GRANT) got_grant <= 1'b1;
            if (pi.kind == K_DATA && pi.last) seen_last <= 1'b1;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!out_vld && !mem_we && !done && !in_rdy));

    // R3: no data leaves before a go-ahead was taken
    a_r3_data_after_grant: assert property (@(posedge clk) disable iff (rst)
        (out_vld && po.kind == K_DATA) |-> got_grant);

    // R8: stored word equals forwarded word
    a_r8_fwd_matches_store: assert property (@(posedge clk) disable iff (rst)
        (mem_we && out_vld) |-> (po.body == mem_wdata));

    // R9: no store while the forward path is stalled
    a_r9_no_store_on_stall: assert property (@(posedge clk) disable iff (rst)
        (mem_we && out_vld) |-> out_rdy);

    // R10: completion only after the final word
    a_r10_fin_after_last: assert property (@(posedge clk) disable iff (rst)
        (out_vld && po.kind == K_FIN) |-> seen_last);

    // R5: done holds until a new start
    a_r5_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
endmodule

bind chain_dma_endpoint chain_dma_endpoint_chk u_chk (.*);

// File: tb/chain_dma_endpoint_test.sv
module chain_dma_endpoint_test;
    import chain_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_FOL    = 4;
    localparam int LEN_W      = 8;
    localparam int CNT_W      = $clog2(MAX_FOL + 1);
    localparam int IDX_W      = $clog2(MAX_FOL);

    typedef struct packed {
        logic [MADDR_W-1:0] a;
        logic [WORD_W-1:0]  d;
    } wr_t;

    logic clk, rst, start, role_init, tbl_we, in_vld, in_rdy, out_vld, out_rdy, mem_we, done;
    logic [NODE_W-1:0]  my_addr, tbl_node;
    logic [CNT_W-1:0]   fol_cnt;
    logic [LEN_W-1:0]   xfer_len;
    logic [MADDR_W-1:0] src_base, tbl_base, mem_waddr, mem_raddr;
    logic [IDX_W-1:0]   tbl_idx;
    logic [PKT_W-1:0]   in_pkt, out_pkt;
    logic [WORD_W-1:0]  mem_wdata, mem_rdata;

    pkt_t  exp_pkt[$];
    string exp_pkt_tag[$];
    wr_t   exp_wr[$];
    string exp_wr_tag[$];
    int    errors = 0, checks = 0, cyc = 0;
    bit    bp_en = 0, bp_chk = 0;
    string phase_tag = "R1";

    chain_dma_endpoint #(.MAX_FOL(MAX_FOL), .LEN_W(LEN_W)) uut (.*);

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [WORD_W-1:0] src_word(logic [MADDR_W-1:0] a);
        return 32'hA500_0000 ^ (32'(a) * 32'h0101_0101 + 32'd7);
    endfunction
    assign mem_rdata = src_word(mem_raddr);

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    always begin
        @(posedge clk);
        cyc++;
        #1;
        out_rdy = bp_en ? ((cyc % 3) != 1) : 1'b1;
    end

    // monitor: pops expected items as the design produces them
    always @(negedge clk) begin
        if (!rst) begin
            if (out_vld && out_rdy) begin
                if (exp_pkt.size() == 0)
                    check(0, phase_tag, "unexpected packet", 64'(out_pkt), 64'h0);
                else begin
                    pkt_t e;
                    string t;
                    e = exp_pkt.pop_front();
                    t = exp_pkt_tag.pop_front();
                    check(out_pkt == e, t, "packet", 64'(out_pkt), 64'(e));
                end
            end
            if (mem_we) begin
                if (exp_wr.size() == 0)
                    check(0, phase_tag, "unexpected write", {mem_waddr, mem_wdata}, 64'h0);
                else begin
                    wr_t w;
                    string t;
                    w = exp_wr.pop_front();
                    t = exp_wr_tag.pop_front();
                    check({mem_waddr, mem_wdata} == w, t, "write", {mem_waddr, mem_wdata}, 64'(w));
                end
            end
            if (bp_chk && in_vld && !out_rdy)
                check(!in_rdy && !mem_we, "R9", "stall taken", {in_rdy, mem_we}, 64'h0);
        end
    end

    task automatic push_pkt(pkt_t p, string t);
        exp_pkt.push_back(p);
        exp_pkt_tag.push_back(t);
    endtask

    task automatic push_wr(logic [MADDR_W-1:0] a, logic [WORD_W-1:0] d, string t);
        exp_wr.push_back('{a: a, d: d});
        exp_wr_tag.push_back(t);
    endtask

    task automatic send_pkt(pkt_t p);
        @(posedge clk); #1;
        in_vld = 1'b1;
        in_pkt = p;
        forever begin
            @(negedge clk);
            if (in_rdy) break;
        end
        @(posedge clk); #1;
        in_vld = 1'b0;
    endtask

    task automatic pulse_start(bit head, logic [NODE_W-1:0] me);
        @(posedge clk); #1;
        role_init = head; my_addr = me; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 300 && (exp_pkt.size() != 0 || exp_wr.size() != 0); i++)
            @(negedge clk);
        check(exp_pkt.size() == 0 && exp_wr.size() == 0, phase_tag, "items not produced",
              64'(exp_pkt.size() + exp_wr.size()), 64'h0);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        rst = 1'b1; start = 0; role_init = 0; my_addr = 0; fol_cnt = 0; xfer_len = 0;
        src_base = 0; tbl_we = 0; tbl_idx = 0; tbl_node = 0; tbl_base = 0;
        in_vld = 0; in_pkt = '0; out_rdy = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_vld && !mem_we && !done && !in_rdy, "R1", "reset outputs",
              {out_vld, mem_we, done, in_rdy}, 64'h0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(!out_vld && !mem_we && !done && !in_rdy, "R1", "after reset",
              {out_vld, mem_we, done, in_rdy}, 64'h0);

        // ---------------- head: members 2,3,4 ----------------
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            tbl_we = 1; tbl_idx = IDX_W'(i); tbl_node = NODE_W'(i + 2); tbl_base = MADDR_W'(8'h40 + 16*i);
        end
        @(posedge clk); #1 tbl_we = 0;
        fol_cnt = 3; xfer_len = 5; src_base = 8'h08;
        phase_tag = "R2";
        push_pkt(make_pkt(K_CFG, 4'd2, 4'd1, 0, pack_link('{prev: 4'd1, next: 4'd3, base: 8'h40})), "R2");
        push_pkt(make_pkt(K_CFG, 4'd3, 4'd1, 0, pack_link('{prev: 4'd2, next: 4'd4, base: 8'h50})), "R2");
        push_pkt(make_pkt(K_CFG, 4'd4, 4'd1, 0, pack_link('{prev: 4'd3, next: 4'hF, base: 8'h60})), "R2");
        bp_en = 1;
        pulse_start(1'b1, 4'd1);
        wait_drain();
        phase_tag = "R3";
        repeat (5) @(negedge clk);
        check(!out_vld, "R3", "data before go-ahead", 64'(out_vld), 64'h0);
        for (int k = 0; k < 5; k++)
            push_pkt(make_pkt(K_DATA, 4'd2, 4'd1, k == 4, src_word(MADDR_W'(8 + k))), "R4");
        phase_tag = "R4";
        send_pkt(make_pkt(K_GRANT, 4'd1, 4'd2, 0, '0));
        wait_drain();
        bp_en = 0;
        repeat (2) @(negedge clk);
        check(!done, "R5", "done before completion", 64'(done), 64'h0);
        send_pkt(make_pkt(K_FIN, 4'd1, 4'd2, 0, '0));
        @(negedge clk);
        check(done, "R5", "done after completion", 64'(done), 64'h1);
        repeat (3) @(negedge clk);
        check(done, "R5", "done held", 64'(done), 64'h1);

        // ---------------- middle member 3 ----------------
        do_reset();
        phase_tag = "R6";
        pulse_start(1'b0, 4'd3);
        send_pkt(make_pkt(K_CFG, 4'd3, 4'd1, 0, pack_link('{prev: 4'd2, next: 4'd4, base: 8'h10})));
        repeat (4) @(negedge clk);
        check(!out_vld, "R6", "go-ahead before downstream", 64'(out_vld), 64'h0);
        push_pkt(make_pkt(K_GRANT, 4'd2, 4'd3, 0, '0), "R6");
        send_pkt(make_pkt(K_GRANT, 4'd3, 4'd4, 0, '0));
        wait_drain();
        // R11: wrong kind while awaiting data
        phase_tag = "R11";
        @(posedge clk); #1;
        in_vld = 1; in_pkt = make_pkt(K_GRANT, 4'd3, 4'd2, 0, '0);
        @(negedge clk);
        check(!in_rdy && !out_vld, "R11", "wrong kind taken", {in_rdy, out_vld}, 64'h0);
        @(negedge clk);
        check(!in_rdy && !out_vld, "R11", "wrong kind taken", {in_rdy, out_vld}, 64'h0);
        @(posedge clk); #1 in_vld = 0;
        phase_tag = "R8";
        bp_en = 1; bp_chk = 1;
        for (int k = 0; k < 6; k++) begin
            logic [WORD_W-1:0] w;
            w = 32'hC0DE_0000 + 32'(k * 17);
            push_pkt(make_pkt(K_DATA, 4'd4, 4'd3, k == 5, w), "R8");
            push_wr(MADDR_W'(8'h10 + k), w, "R8");
        end
        for (int k = 0; k < 6; k++)
            send_pkt(make_pkt(K_DATA, 4'd3, 4'd2, k == 5, 32'hC0DE_0000 + 32'(k * 17)));
        wait_drain();
        bp_en = 0; bp_chk = 0;
        phase_tag = "R10";
        repeat (4) @(negedge clk);
        check(!out_vld && !done, "R10", "completion before downstream", {out_vld, done}, 64'h0);
        push_pkt(make_pkt(K_FIN, 4'd2, 4'd3, 0, '0), "R10");
        send_pkt(make_pkt(K_FIN, 4'd3, 4'd4, 0, '0));
        wait_drain();
        @(negedge clk);
        check(done, "R10", "middle done", 64'(done), 64'h1);

        // ---------------- last member 5 ----------------
        do_reset();
        phase_tag = "R7";
        pulse_start(1'b0, 4'd5);
        push_pkt(make_pkt(K_GRANT, 4'd4, 4'd5, 0, '0), "R7");
        send_pkt(make_pkt(K_CFG, 4'd5, 4'd1, 0, pack_link('{prev: 4'd4, next: 4'hF, base: 8'h20})));
        wait_drain();
        phase_tag = "R10";
        bp_en = 1;
        for (int k = 0; k < 3; k++)
            push_wr(MADDR_W'(8'h20 + k), 32'h7700_0000 | 32'(k), "R8");
        push_pkt(make_pkt(K_FIN, 4'd4, 4'd5, 0, '0), "R10");
        for (int k = 0; k < 3; k++)
            send_pkt(make_pkt(K_DATA, 4'd5, 4'd4, k == 2, 32'h7700_0000 | 32'(k)));
        wait_drain();
        bp_en = 0;
        @(negedge clk);
        check(done, "R10", "last member done", 64'(done), 64'h1);

        report();
        $finish;
    end
endmodule